// File: doc/BRIEF.md
# Cascadable 32-Input Priority Encoder

The block reduces 32 active-low request lines to the 5-bit binary index of the highest-numbered asserted request. It is purely combinational. Four identical 8-input slices are ranked from slice 3 (requests 31..24, highest) down to slice 0 (requests 7..0). Priority passes down the ranks through an enable chain. A slice whose enable is asserted and which sees no request of its own asserts its enable output, and that output enables the next slice down. The slice that finds a request asserts its group-select output. Its enable output stays deasserted, so every slice below it is shut off.

The top level encodes the four group-select lines into the two high index bits. It merges the slices' 3-bit low codes into the three low index bits, and only the single active slice drives its code. Every input and every output is active-low. The index comes out inverted: index 5 reads as `11010`. An overall group-select marks a valid index. The overall enable output is asserted when the block is enabled and no request is present, so a further encoder can be chained below this one.

Top module: `penc_cascade32`

## Requirements
- R1: Within a slice the asserted request with the highest position wins, and its 3-bit position appears inverted on that slice's low code. Position 7 beats all other positions in the slice.
- R2: A slice asserts (drives low) its group-select only when its enable input is low and at least one of its eight requests is low.
- R3: A slice asserts its enable output only when its enable input is low and none of its requests is low. Group-select and enable output are never both low.
- R4: A slice whose enable input is high drives its low code, its group-select and its enable output all high.
- R5: The top enable `en_ni` enables slice 3. The enable chain then runs from slice 3 to slice 2, from slice 2 to slice 1 and from slice 1 to slice 0. Any request in a higher slice therefore overrides every request in the lower slices.
- R6: Index bits 4:3 give the number of the active slice, inverted: slice 3 gives `00`, slice 2 `01`, slice 1 `10` and slice 0 `11`. Index bits 2:0 are the active slice's low code.
- R7: With `en_ni` low and at least one request low, `gs_no` is low, `eo_no` is high, and `addr_no` equals the bitwise inverse of the highest asserted request's position (0..31).
- R8: With `en_ni` low and all requests high, `addr_no` is `11111`, `gs_no` is high and `eo_no` is low.
- R9: With `en_ni` high, `addr_no` is `11111` and `gs_no` and `eo_no` are both high, whatever the requests are.
- R10: At most one slice asserts group-select at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_ni | input | 1 | Active-low enable of the whole encoder (enables slice 3) |
| req_ni | input | 32 | Active-low requests; bit 31 has the highest priority |
| addr_no | output | 5 | Inverted index of the winning request |
| gs_no | output | 1 | Active-low: a valid index is present |
| eo_no | output | 1 | Active-low: enabled and no request present; drives a further encoder below |

## Verification
The case that is hardest to reach from the ports is a win in slice 0. It needs all 24 upper requests deasserted while the block stays enabled, so the enable has to pass through three slices in turn. Random 32-bit patterns almost never produce it. The stimulus therefore forces all request bits above a chosen slice boundary high, and it cycles the boundary through all four slices. This gives every rank of the chain its share of wins. Walking single requests and pairs that straddle the 7/8, 15/16 and 23/24 boundaries cover each pair of neighbouring slices.

// File: rtl/penc_pkg.sv
package penc_pkg;
  localparam int unsigned SLICE_W  = 8;
  localparam int unsigned N_SLICES = 4;
endpackage

// File: rtl/penc_slice.sv
module penc_slice #(
  parameter int unsigned W  = penc_pkg::SLICE_W,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          en_ni,
  input  logic [W-1:0]  req_ni,
  output logic [CW-1:0] code_no,
  output logic          gs_no,
  output logic          eo_no
);
  logic          any_req;
  logic [CW-1:0] win_idx;

  always_comb begin
    any_req = 1'b0;
    win_idx = '0;
    // ascending scan: the last hit is the highest position
    for (int i = 0; i < W; i++) begin
      if (!req_ni[i]) begin
        any_req = 1'b1;
        win_idx = CW'(i);
      end
    end
  end

  always_comb begin
    code_no = '1;
    gs_no   = 1'b1;
    eo_no   = 1'b1;
    if (!en_ni) begin
      if (any_req) begin
        code_no = ~win_idx;
        gs_no   = 1'b0;
      end else begin
        eo_no = 1'b0;
      end
    end
  end

  always_comb begin
    AST_SLICE_EXCL: assert (gs_no || eo_no); // R3
    if (en_ni) begin
      AST_SLICE_OFF: assert (gs_no && eo_no && (&code_no)); // R4
    end
    if (!gs_no) begin
      AST_SLICE_WIN: assert (!req_ni[~code_no]); // R1
      AST_SLICE_GS_EN: assert (!en_ni); // R2
    end
  end
endmodule

// File: rtl/penc_merge.sv
module penc_merge #(
  parameter int unsigned N  = penc_pkg::N_SLICES,
  parameter int unsigned CW = 3,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0]         gs_ni,
  input  logic [N-1:0][CW-1:0] code_ni,
  output logic [SW+CW-1:0]     addr_no,
  output logic                 gs_no
);
  logic [SW-1:0] hi_n;
  logic [CW-1:0] lo_n;

  // active-low OR is an AND
  always_comb begin
    for (int b = 0; b < int'(SW); b++) begin
      hi_n[b] = 1'b1;
      for (int s = 0; s < int'(N); s++) begin
        if (((s >> b) & 1) == 1) hi_n[b] = hi_n[b] & gs_ni[s];
      end
    end
    lo_n = '1;
    for (int s = 0; s < int'(N); s++) lo_n = lo_n & code_ni[s];
  end

  assign addr_no = {hi_n, lo_n};
  assign gs_no   = &gs_ni;

  always_comb begin
    AST_ONE_GROUP: assert ($onehot0(~gs_ni)); // R10
  end
endmodule

// File: rtl/penc_cascade32.sv
module penc_cascade32 #(
  parameter int unsigned W  = penc_pkg::SLICE_W,
  parameter int unsigned N  = penc_pkg::N_SLICES,
  localparam int unsigned CW = $clog2(W),
  localparam int unsigned AW = $clog2(W * N)
) (
  input  logic           en_ni,
  input  logic [W*N-1:0] req_ni,
  output logic [AW-1:0]  addr_no,
  output logic           gs_no,
  output logic           eo_no
);
  logic [N:0]          en_chain_n;
  logic [N-1:0]        gs_n;
  logic [N-1:0][CW-1:0] code_n;

  assign en_chain_n[N] = en_ni;

  for (genvar s = 0; s < int'(N); s++) begin : g_slice
    penc_slice #(.W(W)) u_slice (
      .en_ni   (en_chain_n[s+1]),
      .req_ni  (req_ni[s*W +: W]),
      .code_no (code_n[s]),
      .gs_no   (gs_n[s]),
      .eo_no   (en_chain_n[s])
    );
  end

  assign eo_no = en_chain_n[0];

  penc_merge #(.N(N), .CW(CW)) u_merge (
    .gs_ni   (gs_n),
    .code_ni (code_n),
    .addr_no (addr_no),
    .gs_no   (gs_no)
  );

  always_comb begin
    if (!en_ni && (~req_ni != '0)) begin
      AST_VALID_HIT: assert (!gs_no && eo_no); // R7
      AST_HIT_ASSERTED: assert (!req_ni[~addr_no]); // R7
    end
    if (!en_ni && (&req_ni)) begin
      AST_IDLE_PASS: assert (gs_no && !eo_no && (&addr_no)); // R8
    end
    if (en_ni) begin
      AST_DISABLED: assert (gs_no && eo_no && (&addr_no)); // R9
    end
    if (!gs_no) begin
      AST_HI_MATCH: assert (gs_n[~addr_no[AW-1:CW]] == 1'b0); // R6
    end
  end
endmodule

// File: tb/penc_cascade32_tb.sv
module penc_cascade32_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      tag;
    logic [4:0] addr;
    logic       gs;
    logic       eo;
  } exp_t;

  logic        clk = 1'b0;
  logic        en_ni = 1'b1;
  logic [31:0] req_ni = '1;
  logic [4:0]  addr_no;
  logic        gs_no, eo_no;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  penc_cascade32 u_dut (
    .en_ni   (en_ni),
    .req_ni  (req_ni),
    .addr_no (addr_no),
    .gs_no   (gs_no),
    .eo_no   (eo_no)
  );

  function automatic exp_t model(input logic en, input logic [31:0] req, input string tag);
    exp_t e;
    e.tag = tag; e.addr = 5'h1f; e.gs = 1'b1; e.eo = 1'b1;
    if (!en) begin
      e.eo = 1'b0;
      for (int i = 31; i >= 0; i--) begin
        if (!req[i]) begin
          e.addr = ~5'(i); e.gs = 1'b0; e.eo = 1'b1;
          break;
        end
      end
    end
    return e;
  endfunction

  task automatic apply(input logic en, input logic [31:0] req, input string tag);
    @(negedge clk);
    en_ni  = en;
    req_ni = req;
    q.push_back(model(en, req, tag));
  endtask

  // monitor: compare half a period after the inputs change
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (addr_no !== e.addr || gs_no !== e.gs || eo_no !== e.eo) begin
        n_fail++;
        $display("FAIL %s: addr=%b/%b gs=%b/%b eo=%b/%b (actual/expected)",
                 e.tag, addr_no, e.addr, gs_no, e.gs, eo_no, e.eo);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1d2c3b4a;
    // idle state: enabled, nothing requested
    apply(1'b0, '1, "R8 idle");
    apply(1'b1, '1, "R9 disabled idle");
    // walking single request: every slice and position
    for (int i = 0; i < 32; i++) apply(1'b0, ~(32'd1 << i), "R6 R7 R2 single");
    // all requested: top wins
    apply(1'b0, '0, "R1 R5 all low");
    // disabled with requests: nothing comes out
    apply(1'b1, '0, "R9 R4 disabled all low");
    apply(1'b1, ~32'h0000_0081, "R9 R4 disabled pair");
    // slice boundaries
    apply(1'b0, ~32'h0000_0180, "R5 boundary 7/8");
    apply(1'b0, ~32'h0001_8000, "R5 boundary 15/16");
    apply(1'b0, ~32'h0180_0000, "R5 boundary 23/24");
    apply(1'b0, ~32'h0000_00ff, "R1 slice0 full");
    apply(1'b0, ~32'h0000_0001, "R3 chain to slice0 lowest");
    apply(1'b0, ~32'h8000_0001, "R5 R10 extremes");
    // pseudo-random, upper slices masked to vary the winning rank
    for (int k = 0; k < 400; k++) begin
      logic [31:0] mask;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      mask = (k % 4 == 3) ? 32'h0 : (32'hffff_ffff << (8 * ((k % 4) + 1)));
      apply(k % 9 == 8, lfsr | mask, "R1 R5 R10 random");
    end
    apply(1'b0, '1, "R8 R3 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule